// File: doc/BRIEF.md
# Event RAM Readout Address Sequencer

This block walks one stored event in the event RAM and issues 16-bit-granular read addresses, so that the event leaves in network order toward a 16-bit transmit FIFO. The RAM stores 64-bit rows. Seen as 16-bit words, every row holds four lanes, and the 16-bit address is the row address times four plus the lane number. Lane 0 is the lowest address of a row.

An event has three parts, and each is walked in its own way. The header is read row by row, rising through the lanes, and lanes marked empty in a build-time mask are skipped. The data part is split into channel groups. Each group has three channel-descriptor rows (ID, stop cell, ROI width) and then the sample rows. Each lane carries one readout chip. A lane is read down its column with a stride of four until its own ROI has been sent. The walk then goes back to the group's first row in the next lane. After lane 3, it moves to the first row of the next group. Rows of a group are spaced by the largest ROI among its four lanes. The footer row is read in lane order: a CRC placeholder word and then the end flag.

A read strobe is raised only while the FIFO is ready. The strobe is delayed by the RAM read latency to give the FIFO write strobe.

Top module: `evt_rd_addr_seq`

## Requirements
- R1: After reset, `rd_en_o` and `fifo_wr_o` stay low until `start_i` is seen with the sequencer idle.
- R2: The header reads are the 16-bit addresses `4*start_row_i + i` in rising `i`, for each set bit `i` of the header lane mask. Bit `4*r+l` means row `r`, lane `l`. The default mask has lanes 0..2 in rows 0..2, lane 0 only in row 3, and all lanes in rows 4..6.
- R3: For group `g` and lane `l`, the reads are `4*(base_g+k)+l` for `k = 0 .. 2+roi(g,l)`, so the address rises by 4 per read. Lanes run 0,1,2,3, and each lane restarts at row `base_g`.
- R4: `base_0 = start_row_i + HDR_ROWS`, and `base_(g+1) = base_g + 3 + max over l of roi(g,l)`. `roi(g,l)` is `roi_i[(4*g+l)*ROI_W +: ROI_W]`.
- R5: After the last group, two footer reads are issued at `4*base_NG + 0` and then at `4*base_NG + 1`.
- R6: While `fifo_ready_i` is low, `rd_en_o` is low and the read address holds. No word of the sequence is lost or repeated.
- R7: `fifo_wr_o` equals `rd_en_o` delayed by the RAM read latency of one cycle.
- R8: A `start_i` pulse during an event is ignored. After the second footer read, no further reads occur until a new start.
- R9: All addresses wrap modulo `2^ADDR_W`.
- R10: A lane whose ROI is 0 sends only its three descriptor words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin walking one event (taken only when idle) |
| start_row_i | input | ADDR_W-2 | 64-bit row address of the event start |
| roi_i | input | NUM_GROUPS*4*ROI_W | ROI of every lane of every group |
| fifo_ready_i | input | 1 | FIFO can accept a word |
| rd_addr_o | output | ADDR_W | 16-bit read address into the RAM |
| rd_en_o | output | 1 | RAM read strobe for `rd_addr_o` |
| fifo_wr_o | output | 1 | Data-valid write strobe to the FIFO |

## Verification
The risky overlaps are a FIFO stall landing on a boundary cycle, and a start pulse landing mid-event. A boundary cycle is the last word of a lane, a group, the header or the footer. In a stall, the boundary step must wait without skipping or repeating an address. A mid-event start must not restart the walk. The bench sweeps several ROI patterns, start rows and ready patterns (steady, alternating, sparse, bursty) so that stalls fall on these boundaries. It injects a start pulse part-way through every event. Every issued address is compared with a sequence computed arithmetically from the requirements, and idle cycles after each event are checked for stray reads.

// File: rtl/evt_rd_pkg.sv
package evt_rd_pkg;

  localparam int LANES       = 4;
  localparam int LANE_W      = 2;
  localparam int DESC_ROWS   = 3;
  localparam int TAIL_WORDS  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DAT  = 2'd2,
    ST_FTR  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/evt_rd_roi_max.sv
module evt_rd_roi_max
  import evt_rd_pkg::*;
#(
  parameter int NUM_GROUPS = 9,
  parameter int ROI_W      = 11
) (
  input  logic [NUM_GROUPS*LANES*ROI_W-1:0] roi_flat_i,
  output logic [ROI_W-1:0]                  roi_arr_o [NUM_GROUPS][LANES],
  output logic [ROI_W-1:0]                  roi_max_o [NUM_GROUPS]
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [ROI_W-1:0] mx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign roi_arr_o[g][l] = roi_flat_i[(g*LANES+l)*ROI_W +: ROI_W];
    end

    always_comb begin
      mx = roi_flat_i[(g*LANES)*ROI_W +: ROI_W];
      for (int l = 1; l < LANES; l++) begin
        if (roi_flat_i[(g*LANES+l)*ROI_W +: ROI_W] > mx) begin
          mx = roi_flat_i[(g*LANES+l)*ROI_W +: ROI_W];
        end
      end
    end

    assign roi_max_o[g] = mx;
  end

endmodule

// File: rtl/evt_rd_hdr_skip.sv
module evt_rd_hdr_skip #(
  parameter int               HDR_ROWS = 7,
  parameter logic [HDR_ROWS*4-1:0] LANE_MASK = '1,
  localparam int              HW    = HDR_ROWS * 4,
  localparam int              IDX_W = (HW > 1) ? $clog2(HW) : 1
) (
  input  logic [IDX_W-1:0] cur_idx_i,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             nxt_vld_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic             first_vld_o
);

  always_comb begin
    nxt_vld_o = 1'b0;
    nxt_idx_o = '0;
    for (int i = HW - 1; i >= 0; i--) begin
      if (LANE_MASK[i] && (i > int'(cur_idx_i))) begin
        nxt_vld_o = 1'b1;
        nxt_idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    first_vld_o = 1'b0;
    first_idx_o = '0;
    for (int i = HW - 1; i >= 0; i--) begin
      if (LANE_MASK[i]) begin
        first_vld_o = 1'b1;
        first_idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/evt_rd_lat_pipe.sv
module evt_rd_lat_pipe #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  if (LAT == 0) begin : g_thru
    assign q_o = d_i;
  end else if (LAT == 1) begin : g_one
    logic sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= 1'b0;
      else        sh_q <= d_i;
    end
    assign q_o = sh_q;
  end else begin : g_many
    logic [LAT-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[LAT-2:0], d_i};
    end
    assign q_o = sh_q[LAT-1];
  end

endmodule

// File: rtl/evt_rd_addr_seq.sv
module evt_rd_addr_seq
  import evt_rd_pkg::*;
#(
  parameter int NUM_GROUPS = 9,
  parameter int ROI_W      = 11,
  parameter int ADDR_W     = 14,
  parameter int HDR_ROWS   = 7,
  parameter logic [HDR_ROWS*4-1:0] HDR_LANE_MASK = 28'hFFF1777,
  parameter int RD_LAT     = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [ADDR_W-3:0]                 start_row_i,
  input  logic [NUM_GROUPS*LANES*ROI_W-1:0] roi_i,
  input  logic                              fifo_ready_i,
  output logic [ADDR_W-1:0]                 rd_addr_o,
  output logic                              rd_en_o,
  output logic                              fifo_wr_o
);

  localparam int ROW_W  = ADDR_W - 2;
  localparam int CNT_W  = ROI_W + 1;
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int HW     = HDR_ROWS * 4;
  localparam int HIDX_W = (HW > 1) ? $clog2(HW) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  seq_st_e            st_q,    st_d;
  logic [ROW_W-1:0]   start_q, start_d;
  logic [ROW_W-1:0]   base_q,  base_d;
  logic [HIDX_W-1:0]  hidx_q,  hidx_d;
  logic [GRP_W-1:0]   grp_q,   grp_d;
  logic [LANE_W-1:0]  lane_q,  lane_d;
  logic [CNT_W-1:0]   row_q,   row_d;
  logic [LANE_W-1:0]  tail_q,  tail_d;

  // ROI decode
  logic [ROI_W-1:0] roi_arr [NUM_GROUPS][LANES];
  logic [ROI_W-1:0] roi_max [NUM_GROUPS];

  evt_rd_roi_max #(
    .NUM_GROUPS (NUM_GROUPS),
    .ROI_W      (ROI_W)
  ) u_roi_max (
    .roi_flat_i (roi_i),
    .roi_arr_o  (roi_arr),
    .roi_max_o  (roi_max)
  );

  // header lane search
  logic [HIDX_W-1:0] hnxt_idx, hfirst_idx;
  logic              hnxt_vld, hfirst_vld;

  evt_rd_hdr_skip #(
    .HDR_ROWS  (HDR_ROWS),
    .LANE_MASK (HDR_LANE_MASK)
  ) u_hdr_skip (
    .cur_idx_i   (hidx_q),
    .nxt_idx_o   (hnxt_idx),
    .nxt_vld_o   (hnxt_vld),
    .first_idx_o (hfirst_idx),
    .first_vld_o (hfirst_vld)
  );

  // step conditions
  logic [ROI_W-1:0] lane_roi;
  logic [ROI_W-1:0] grp_span;
  logic             active;
  logic             adv;
  logic             lane_last;
  logic             grp_last;
  logic             tail_last;
  logic [ROW_W-1:0] next_base;
  logic [ROW_W-1:0] dat_row;

  assign lane_roi  = roi_arr[grp_q][lane_q];
  assign grp_span  = roi_max[grp_q];
  assign active    = (st_q != ST_IDLE);
  assign adv       = active && fifo_ready_i;
  assign lane_last = (row_q == (CNT_W'(lane_roi) + CNT_W'(DESC_ROWS - 1)));
  assign grp_last  = (grp_q == GRP_W'(NUM_GROUPS - 1));
  assign tail_last = (tail_q == LANE_W'(TAIL_WORDS - 1));
  assign next_base = base_q + ROW_W'(grp_span) + ROW_W'(DESC_ROWS);
  assign dat_row   = base_q + ROW_W'(row_q);

  // address composer
  always_comb begin
    unique case (st_q)
      ST_HDR:  rd_addr_o = {start_q, 2'b00} + ADDR_W'(hidx_q);
      ST_DAT:  rd_addr_o = {dat_row, lane_q};
      ST_FTR:  rd_addr_o = {base_q, tail_q};
      default: rd_addr_o = '0;
    endcase
  end

  assign rd_en_o = adv;

  // next-state
  always_comb begin
    st_d    = st_q;
    start_d = start_q;
    base_d  = base_q;
    hidx_d  = hidx_q;
    grp_d   = grp_q;
    lane_d  = lane_q;
    row_d   = row_q;
    tail_d  = tail_q;

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          start_d = start_row_i;
          base_d  = start_row_i + ROW_W'(HDR_ROWS);
          hidx_d  = hfirst_idx;
          grp_d   = '0;
          lane_d  = '0;
          row_d   = '0;
          tail_d  = '0;
          st_d    = hfirst_vld ? ST_HDR : ST_DAT;
        end
      end
      ST_HDR: begin
        if (adv) begin
          if (hnxt_vld) hidx_d = hnxt_idx;
          else          st_d   = ST_DAT;
        end
      end
      ST_DAT: begin
        if (adv) begin
          if (!lane_last) begin
            row_d = row_q + CNT_W'(1);
          end else begin
            row_d = '0;
            if (lane_q != LANE_W'(LANES - 1)) begin
              lane_d = lane_q + LANE_W'(1);
            end else begin
              lane_d = '0;
              base_d = next_base;
              if (grp_last) begin
                st_d   = ST_FTR;
                tail_d = '0;
              end else begin
                grp_d = grp_q + GRP_W'(1);
              end
            end
          end
        end
      end
      ST_FTR: begin
        if (adv) begin
          if (tail_last) st_d   = ST_IDLE;
          else           tail_d = tail_q + LANE_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      base_q  <= '0;
      hidx_q  <= '0;
      grp_q   <= '0;
      lane_q  <= '0;
      row_q   <= '0;
      tail_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      base_q  <= base_d;
      hidx_q  <= hidx_d;
      grp_q   <= grp_d;
      lane_q  <= lane_d;
      row_q   <= row_d;
      tail_q  <= tail_d;
    end
  end

  // read latency
  evt_rd_lat_pipe #(
    .LAT (RD_LAT)
  ) u_lat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (rd_en_o),
    .q_o   (fifo_wr_o)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && !fifo_ready_i) |=> $stable(rd_addr_o));

  // R3
  col_stride_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_o && st_q == ST_DAT && !lane_last) |=> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(4)));

  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_o && st_q == ST_DAT && lane_last && lane_q != LANE_W'(LANES - 1))
    |=> (rd_addr_o[1:0] == $past(rd_addr_o[1:0]) + 2'd1));

  // R5
  tail_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_o && st_q == ST_FTR && !tail_last) |=> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(1)));

  // R8
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_o && st_q == ST_FTR && tail_last) |=> !rd_en_o);

  // R2
  hdr_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_o && st_q == ST_HDR && hnxt_vld) |=> (st_q == ST_HDR && rd_addr_o != $past(rd_addr_o)));

  if (RD_LAT == 1) begin : g_lat_chk
    // R7
    wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      rd_en_o |=> fifo_wr_o);
    // R7
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !rd_en_o |=> !fifo_wr_o);
  end

endmodule

// File: tb/evt_rd_addr_seq_bench.sv
`timescale 1ns/1ps
module evt_rd_addr_seq_bench;

  localparam int NG     = 2;
  localparam int RW     = 4;
  localparam int AW     = 10;
  localparam int HROWS  = 7;
  localparam int AMOD   = 1 << AW;
  localparam int NCASE  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [AW-3:0]   start_row_i = '0;
  logic [NG*4*RW-1:0] roi_i = '0;
  logic            fifo_ready_i = 1'b0;
  logic [AW-1:0]   rd_addr_o;
  logic            rd_en_o;
  logic            fifo_wr_o;

  always #2.5 clk = ~clk;

  evt_rd_addr_seq #(
    .NUM_GROUPS (NG),
    .ROI_W      (RW),
    .ADDR_W     (AW),
    .HDR_ROWS   (HROWS)
  ) u_evt_rd_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_row_i  (start_row_i),
    .roi_i        (roi_i),
    .fifo_ready_i (fifo_ready_i),
    .rd_addr_o    (rd_addr_o),
    .rd_en_o      (rd_en_o),
    .fifo_wr_o    (fifo_wr_o)
  );

  int checks = 0;
  int errors = 0;
  int exp_addr [1024];
  int exp_n = 0;
  int idx = 0;
  int roi_v [NG][4];
  bit prev_rd = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // header lanes per R2: rows 0..2 lanes 0..2, row 3 lane 0, rows 4..6 all
  function automatic bit hdr_used(input int r, input int l);
    if (r <= 2) return l <= 2;
    if (r == 3) return l == 0;
    return 1'b1;
  endfunction

  task automatic build(input int srow);
    int base;
    int mx;
    exp_n = 0;
    for (int r = 0; r < HROWS; r++)
      for (int l = 0; l < 4; l++)
        if (hdr_used(r, l)) begin
          exp_addr[exp_n] = (srow*4 + r*4 + l) % AMOD; exp_n++;
        end
    base = srow + HROWS;
    for (int g = 0; g < NG; g++) begin
      mx = 0;
      for (int l = 0; l < 4; l++) begin
        if (roi_v[g][l] > mx) mx = roi_v[g][l];
        for (int k = 0; k <= 2 + roi_v[g][l]; k++) begin
          exp_addr[exp_n] = ((base + k)*4 + l) % AMOD; exp_n++;
        end
      end
      base = base + 3 + mx;
    end
    exp_addr[exp_n] = (base*4) % AMOD;     exp_n++;
    exp_addr[exp_n] = (base*4 + 1) % AMOD; exp_n++;
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      chk(fifo_wr_o == prev_rd, "R7 write strobe follows read", int'(fifo_wr_o), int'(prev_rd));
      if (rd_en_o) begin
        chk(fifo_ready_i, "R6 no read while not ready", int'(rd_en_o), 0);
        if (idx >= exp_n) begin
          chk(1'b0, "R8 read after event end", int'(rd_addr_o), -1);
        end else begin
          chk(int'(rd_addr_o) == exp_addr[idx], "R2/R3/R4/R5/R9/R10 address sequence",
              int'(rd_addr_o), exp_addr[idx]);
        end
        idx++;
      end
    end
    prev_rd = rd_en_o;
  end

  function automatic bit ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return ((cyc * 7) % 5) != 0;
      default: return (cyc % 8) < 5;
    endcase
  endfunction

  initial begin
    int cyc;
    int srow;
    // R1: reset state
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    fifo_ready_i = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!rd_en_o, "R1 idle read strobe after reset", int'(rd_en_o), 0);
      chk(!fifo_wr_o, "R1 idle write strobe after reset", int'(fifo_wr_o), 0);
    end
    mon_on = 1'b1;

    for (int t = 0; t < NCASE; t++) begin
      for (int g = 0; g < NG; g++)
        for (int l = 0; l < 4; l++) begin
          if (t == 0)      roi_v[g][l] = 0;              // R10 all lanes empty
          else if (t == 1) roi_v[g][l] = 15;
          else if (t == 2) roi_v[g][l] = (l == 3 - g) ? 9 : 0;
          else             roi_v[g][l] = (t*3 + g*5 + l*7 + t*l) % 16;
        end
      srow = (t == 2 || t == 5) ? 250 : (t * 37) % 256; // R9 wrap cases
      build(srow);
      idx = 0;
      @(posedge clk);
      #1;
      start_row_i = AW'(0) + srow[AW-3:0];
      for (int g = 0; g < NG; g++)
        for (int l = 0; l < 4; l++)
          roi_i[(g*4+l)*RW +: RW] = RW'(roi_v[g][l]);
      start_i = 1'b1;
      fifo_ready_i = ready_pat(t % 4, 0);
      cyc = 0;
      while (idx < exp_n && cyc < 4000) begin
        @(posedge clk);
        #1;
        cyc++;
        start_i = (cyc == 12) || (idx >= exp_n - 1); // R8 start mid-event and at end
        fifo_ready_i = ready_pat(t % 4, cyc);
      end
      if (cyc >= 4000) chk(1'b0, "R6 watchdog event completion", idx, exp_n);
      start_i = 1'b0;
      fifo_ready_i = 1'b1;
      repeat (8) @(posedge clk);
      #1;
      chk(idx == exp_n, "R8 word count per event", idx, exp_n);
    end

    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", idx, exp_n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule